// File: doc/BRIEF.md
# Interval Splitting Control Logic

This block sits in front of a two-stage fine time measurement path. It receives asynchronous start and stop events and a reference clock. It divides the interval between the two events into three parts. The middle part is a whole number of reference clock periods, and the block counts it in a saturating counter. The two outer parts are residual fractions. The first runs from the start event to the next rising clock edge. The second runs from the stop event to the next rising clock edge.

Each residual is presented to the downstream fine-measurement logic as a pulse. The pulse opens at its event and closes at the capturing clock edge. Both events are level-held inputs. Each event passes through a two-flop chain so that exactly one rising edge is taken per measurement. Once the stop edge has been taken, a one-cycle done strobe marks the count as final. The count and the overflow flag then hold until the next start.

The reset is synchronous and active high. The block measures at most 15 whole periods; longer intervals saturate and raise an overflow flag.

Top module: `interval_splitter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 0 and `ovf` and `done` become low in the following cycle.
- R2: `start_res` goes high as soon as `start_in` rises and falls at the first rising `clk` edge after that rise.
- R3: `stop_res` goes high as soon as `stop_in` rises while `start_in` is high, and falls at the first rising `clk` edge after that rise.
- R4: `count` equals the number of rising `clk` edges after the edge that captured the start event, up to and including the edge that captured the stop event.
- R5: When the start and stop events fall in the same clock period, `count` is 0.
- R6: When the whole-period count would exceed 15, `count` stays at 15 and `ovf` goes high. An interval of exactly 15 periods leaves `ovf` low.
- R7: `done` is high for exactly one cycle. It is set at the second rising edge after the stop event, so the result is final 2 cycles after the measurement ends.
- R8: A stop event while `start_in` is low is ignored. It causes no `stop_res` pulse, no `done` and no change of `count`.
- R9: After `done`, `count` and `ovf` hold until the next start event. A new start event clears `ovf` and restarts the count.
- R10: Both inputs are level-held and are taken once per rising level. `start_in` stays high until `done`. A new measurement needs both inputs to have returned low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| start_in | input | 1 | Asynchronous start event, level-held |
| stop_in | input | 1 | Asynchronous stop event, level-held |
| start_res | output | 1 | Start residual pulse: from the start event to the next rising edge |
| stop_res | output | 1 | Stop residual pulse: from the stop event to the next rising edge |
| count | output | CNT_W | Whole reference periods in the interval |
| ovf | output | 1 | Count saturated |
| done | output | 1 | One-cycle strobe: the result is final |

## Verification
The checker watches several properties on every cycle:
- the single-cycle width of `done`;
- that `ovf` is high only with `count` at its ceiling;
- that `count` is frozen in the cycle after `done`;
- that `done` only occurs while both events are held;
- the cleared state after reset.

Some behaviour needs known stimulus timing and only the bench scenarios can show it:
- the exact period count for a given placement of the events;
- the opening and closing of the residual pulses around the capturing edge;
- the same-period case;
- the 15/16-period boundary;
- the ignored early stop.

// File: rtl/tdc_split_pkg.sv
package tdc_split_pkg;
    localparam int TDC_CNT_W = 4;
    localparam int TDC_SYNC_STAGES = 2;

    typedef enum logic {
        SPAN_IDLE = 1'b0,
        SPAN_RUN  = 1'b1
    } span_state_e;
endpackage

// File: rtl/edge_tap.sv
module edge_tap #(
    parameter int STAGES = tdc_split_pkg::TDC_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic evt_in,
    output logic first_q,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = evt_in;
        for (int i = 1; i <= LAST; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign first_q = chain_q[0];
    assign rise    = chain_q[0] & ~chain_q[1];
endmodule

// File: rtl/span_counter.sv
module span_counter
    import tdc_split_pkg::*;
#(
    parameter int CNT_W = TDC_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_rise,
    input  logic             stop_rise,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        span_state_e      state;
        logic [CNT_W-1:0] count;
        logic             ovf;
        logic             done;
    } span_regs_t;

    span_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            SPAN_IDLE: begin
                if (start_rise) begin
                    r_d.ovf = 1'b0;
                    if (stop_rise) begin
                        r_d.count = '0;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.count = CNT_ONE;
                        r_d.state = SPAN_RUN;
                    end
                end
            end
            SPAN_RUN: begin
                if (stop_rise) begin
                    r_d.done  = 1'b1;
                    r_d.state = SPAN_IDLE;
                end else if (r_q.count == CNT_MAX) begin
                    r_d.ovf = 1'b1;
                end else begin
                    r_d.count = r_q.count + CNT_ONE;
                end
            end
            default: r_d.state = SPAN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= SPAN_IDLE;
            r_q.count <= '0;
            r_q.ovf   <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign count = r_q.count;
    assign ovf   = r_q.ovf;
    assign done  = r_q.done;
endmodule

// File: rtl/interval_splitter.sv
module interval_splitter
    import tdc_split_pkg::*;
#(
    parameter int CNT_W  = TDC_CNT_W,
    parameter int STAGES = TDC_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_in,
    input  logic             stop_in,
    output logic             start_res,
    output logic             stop_res,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             done
);
    logic start_q1, start_rise;
    logic stop_q1, stop_rise;

    edge_tap #(.STAGES(STAGES)) u_start_tap (
        .clk(clk), .rst(rst), .evt_in(start_in),
        .first_q(start_q1), .rise(start_rise)
    );

    edge_tap #(.STAGES(STAGES)) u_stop_tap (
        .clk(clk), .rst(rst), .evt_in(stop_in),
        .first_q(stop_q1), .rise(stop_rise)
    );

    // Residual windows close when the first flop of each chain has taken the event.
    assign start_res = start_in & ~start_q1;
    assign stop_res  = stop_in & ~stop_q1 & start_in;

    span_counter #(.CNT_W(CNT_W)) u_span (
        .clk(clk), .rst(rst),
        .start_rise(start_rise), .stop_rise(stop_rise),
        .count(count), .ovf(ovf), .done(done)
    );
endmodule

// File: rtl/interval_splitter_chk.sv
module interval_splitter_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start_in,
    input logic             stop_in,
    input logic [CNT_W-1:0] count,
    input logic             ovf,
    input logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (count == '0 && !ovf && !done)); // R1

    AST_OVF_SATURATED: assert property (@(posedge clk) disable iff (rst)
        ovf |-> count == CNT_MAX); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        done |-> (start_in && stop_in)); // R8

    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(count) && $stable(ovf))); // R9
endmodule

bind interval_splitter interval_splitter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .start_in(start_in), .stop_in(stop_in),
    .count(count), .ovf(ovf), .done(done)
);

// File: tb/interval_splitter_test.sv
module interval_splitter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_in = 1'b0;
    logic       stop_in = 1'b0;
    logic       start_res, stop_res, ovf, done;
    logic [3:0] count;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    interval_splitter uut (
        .clk(clk), .rst(rst), .start_in(start_in), .stop_in(stop_in),
        .start_res(start_res), .stop_res(stop_res),
        .count(count), .ovf(ovf), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic release_inputs();
        start_in = 1'b0;
        stop_in  = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    // k whole periods between the capturing edges of start and stop
    task automatic measure(input int k, input logic [3:0] exp_cnt, input logic exp_ovf);
        @(posedge clk); #5;
        start_in = 1'b1;
        #1 check("R2 start_res opens", start_res, 1);
        if (k == 0) begin
            #1 stop_in = 1'b1;
            #1 check("R3 stop_res opens", stop_res, 1);
        end
        @(posedge clk); #1;
        check("R2 start_res closes", start_res, 0);
        if (k > 0) begin
            repeat (k - 1) @(posedge clk);
            #5 stop_in = 1'b1;
            #1 check("R3 stop_res opens", stop_res, 1);
            @(posedge clk); #1;
        end
        check("R3 stop_res closes", stop_res, 0);
        check("R7 done low one cycle after capture", done, 0);
        @(posedge clk); #1;
        check("R7 done high", done, 1);
        check("R4 R5 R6 count", count, exp_cnt);
        check("R6 ovf", ovf, exp_ovf);
        @(posedge clk); #1;
        check("R7 done single cycle", done, 0);
        check("R9 count holds", count, exp_cnt);
        release_inputs();
        #1 check("R9 count holds after release", count, exp_cnt);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1 count", count, 0);
        check("R1 ovf", ovf, 0);
        check("R1 done", done, 0);
        rst = 1'b0;
    endtask

    task automatic t_ignored_stop(input logic [3:0] prev);
        @(posedge clk); #5;
        stop_in = 1'b1;
        #1 check("R8 no stop_res without start", stop_res, 0);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            check("R8 no done", done, 0);
        end
        check("R8 count unchanged", count, prev);
        release_inputs();
    endtask

    task automatic t_overflow_clear();
        measure(20, 4'd15, 1'b1);
        check("R9 ovf holds", ovf, 1);
        measure(2, 4'd2, 1'b0);
    endtask

    initial begin
        #(20 * 20000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        measure(3, 4'd3, 1'b0);   // R4
        measure(0, 4'd0, 1'b0);   // R5
        measure(1, 4'd1, 1'b0);   // R4
        measure(7, 4'd7, 1'b0);   // R4
        measure(15, 4'd15, 1'b0); // R6 boundary
        measure(16, 4'd15, 1'b1); // R6
        t_ignored_stop(4'd15);    // R8
        measure(4, 4'd4, 1'b0);   // R10 re-arm after both low
        t_overflow_clear();       // R9
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule